// File: doc/BRIEF.md
# Single-Line Serial Register Port for a Real-Time Clock

This block is the host-side access path of a real-time clock whose sixteen byte-wide registers are reached one bit at a time over a single data line of a parallel bus. Each qualified bus strobe moves exactly one bit. A frame is twelve strobes long: four write strobes that carry a register address, followed by eight strobes that either shift a register's contents out or shift a new byte in. Two strobe conventions are supported. One uses a pair of separate active-low read and write strobes. The other uses one active-low data strobe plus a direction level. Both are gated by an active-low chip select.

The register file is an internal array. When the address is complete, the addressed byte is copied into a data shift register. A read frame therefore returns one consistent byte, and it does not matter what happens to the array during the frame. A write frame commits the assembled byte when its twelfth strobe ends. While chip select is high, bit 0 of register 0 selects what the data line does. When that bit is 0 the line is released. When it is 1 the line carries a 256 Hz square wave made from a 32.768 kHz tick.

All bus inputs are taken as already synchronous to `clk`. The tri-state pad sits outside the block and is driven from `dio_o` and `dio_oe`.

Top module: `rtc_bit_port`

## Requirements
- R1: After reset, all registers read 0, the bit counter points at the first address bit, and `dio_oe` is 0 while `cs_n` is high.
- R2: The first four counted accesses of a frame are writes that form the register address, least-significant bit first. Address 12 is sent as 0,0,1,1.
- R3: A read strobe during the address phase is ignored. It does not advance the frame and `dio_oe` stays 0.
- R4: In the data phase, `dio_oe` is 1 in the same cycle in which chip select and the read strobe are both active, and `dio_o` shows the current bit. `dio_oe` falls in the cycle in which either signal deasserts first. Bits leave least-significant first.
- R5: A write access stores the `dio_i` level of the last cycle in which its pulse was active. Eight data writes form the byte least-significant first, and the byte is committed to the addressed register when the twelfth access, a write, ends.
- R6: The addressed byte is copied into the data shift register when the fourth address bit ends. A frame of eight data reads returns that byte and leaves the register unchanged.
- R7: With `bus_mode`=1, an access is `cs_n`=0 and `ds_n`=0. The `rw` level present when the data strobe asserts sets the direction (1 = read). Later changes of `rw` during that strobe are ignored.
- R8: With `bus_mode`=0 and both `rd_n` and `wr_n` low, no access takes place. The frame does not advance and `dio_oe` stays 0.
- R9: A cycle with `frame_rst`=1 returns the bit counter to the first address bit.
- R10: After the twelfth access the counter wraps, so the next access is address bit 0 of a new frame. No frame reset is needed.
- R11: With `cs_n` high, `dio_oe` equals bit 0 of register 0. When that bit is 1, `dio_o` is a square wave of period 128 ticks of `tick_32k`: low for the first 64 ticks after reset, then high for 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | 0 = separate read/write strobes, 1 = data strobe with direction |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe (bus_mode 0) |
| wr_n | input | 1 | Active-low write strobe (bus_mode 0) |
| ds_n | input | 1 | Active-low data strobe (bus_mode 1) |
| rw | input | 1 | Direction, 1 = read (bus_mode 1) |
| frame_rst | input | 1 | Restart the frame at address bit 0 |
| tick_32k | input | 1 | One-cycle 32.768 kHz enable |
| dio_i | input | 1 | Data line level from the pad |
| dio_o | output | 1 | Data line value toward the pad |
| dio_oe | output | 1 | Pad drive enable |

## Verification
The line drive follows the strobes combinationally. For this reason the bench checks `dio_oe` and `dio_o` at the falling clock edge that follows a strobe change, which is inside the same cycle. Counter steps, address capture, the shift of the data register and the commit all happen at the rising edge after a strobe ends, so the bench always idles for at least one full cycle before the next strobe. A monitor records a read bit when the drive window closes and compares each group of eight bits with the byte that the driver queued. The square-wave checks are made at the falling edge after the 64th and 128th tick, once the tick counter has registered them.

// File: rtl/rtc_bit_pkg.sv
package rtc_bit_pkg;

    localparam int ADDR_W_DEF   = 4;
    localparam int DATA_W_DEF   = 8;
    localparam int TONE_DIV_DEF = 128;

    // Access kind, one flag per direction.
    typedef struct packed {
        logic rd;
        logic wr;
    } acc_t;

    typedef enum logic {
        BUS_STROBE_PAIR = 1'b0,
        BUS_DATA_STROBE = 1'b1
    } bus_e;

    // Flags that were set last cycle and are clear now.
    function automatic acc_t acc_end(acc_t prev, acc_t now);
        acc_t r;
        r.rd = prev.rd & ~now.rd;
        r.wr = prev.wr & ~now.wr;
        return r;
    endfunction

endpackage

// File: rtl/rtc_bit_strobe.sv
module rtc_bit_strobe
    import rtc_bit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_mode,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic ds_n,
    input  logic rw,
    output acc_t act,
    output acc_t fin
);
    logic  sel;
    logic  ds_on;
    logic  ds_q;
    logic  rw_lat;
    logic  dir_rd;
    acc_t  pair_acc;
    acc_t  ds_acc;
    acc_t  act_q;

    assign sel   = ~cs_n;
    assign ds_on = sel & ~ds_n;

    // Direction is fixed at data-strobe assertion.
    assign dir_rd = ds_q ? rw_lat : rw;

    always_comb begin
        pair_acc.rd = sel & ~rd_n & wr_n;
        pair_acc.wr = sel & ~wr_n & rd_n;
        ds_acc.rd   = ds_on & dir_rd;
        ds_acc.wr   = ds_on & ~dir_rd;
        act = (bus_e'(bus_mode) == BUS_DATA_STROBE) ? ds_acc : pair_acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ds_q   <= 1'b0;
            rw_lat <= 1'b0;
            act_q  <= '0;
        end else begin
            ds_q  <= ds_on;
            act_q <= act;
            if (ds_on && !ds_q) begin
                rw_lat <= rw;
            end
        end
    end

    assign fin = acc_end(act_q, act);

endmodule

// File: rtl/rtc_bit_frame.sv
module rtc_bit_frame
    import rtc_bit_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    localparam int FRAME_LEN = ADDR_W + DATA_W,
    localparam int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              act,
    input  acc_t              fin,
    input  logic              dio_i,
    input  logic              frame_rst,
    input  logic [DATA_W-1:0] snap_data,
    output logic [ADDR_W-1:0] snap_addr,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              data_phase,
    output logic              out_bit,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);

    logic [ADDR_W-1:0] addr_sr;
    logic [DATA_W-1:0] data_sr;
    logic              wbit;
    logic              count_ev;
    logic              last_bit;
    logic              load_snap;
    logic              shift_ev;
    logic              ins_bit;

    assign data_phase = bit_cnt > ADDR_LAST;
    assign count_ev   = ~frame_rst & (fin.wr | (fin.rd & data_phase));
    assign last_bit   = bit_cnt == FRAME_LAST;
    assign load_snap  = ~frame_rst & fin.wr & (bit_cnt == ADDR_LAST);
    assign shift_ev   = count_ev & data_phase;
    assign ins_bit    = fin.wr ? wbit : data_sr[0];
    assign snap_addr  = {wbit, addr_sr[ADDR_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            addr_sr <= '0;
            data_sr <= '0;
            wbit    <= 1'b0;
        end else begin
            if (act.wr) begin
                wbit <= dio_i;
            end
            if (frame_rst) begin
                bit_cnt <= '0;
            end else if (count_ev) begin
                bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
            end
            if (count_ev && !data_phase) begin
                addr_sr <= snap_addr;
            end
            if (load_snap) begin
                data_sr <= snap_data;
            end else if (shift_ev) begin
                data_sr <= {ins_bit, data_sr[DATA_W-1:1]};
            end
        end
    end

    assign out_bit = data_sr[0];
    assign wr_en   = ~frame_rst & fin.wr & last_bit;
    assign wr_addr = addr_sr;
    assign wr_data = {wbit, data_sr[DATA_W-1:1]};

endmodule

// File: rtl/rtc_bit_regs.sv
module rtc_bit_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tone_sel
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data  = mem[rd_addr];
    assign tone_sel = mem[0][0];

endmodule

// File: rtl/rtc_bit_tone.sv
module rtc_bit_tone #(
    parameter int TONE_DIV = 128,
    localparam int DIV_W = $clog2(TONE_DIV)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic tone
);
    logic [DIV_W-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Top bit: low for the first half of each period, high for the second.
    assign tone = div_cnt[DIV_W-1];

endmodule

// File: rtl/rtc_bit_port.sv
module rtc_bit_port
    import rtc_bit_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int TONE_DIV = TONE_DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_mode,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic ds_n,
    input  logic rw,
    input  logic frame_rst,
    input  logic tick_32k,
    input  logic dio_i,
    output logic dio_o,
    output logic dio_oe
);
    localparam int CNT_W = $clog2(ADDR_W + DATA_W);

    acc_t              act;
    acc_t              fin;
    logic [CNT_W-1:0]  bit_cnt;
    logic              data_phase;
    logic              out_bit;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] snap_addr;
    logic [DATA_W-1:0] snap_data;
    logic              tone_sel;
    logic              tone;
    logic              rd_drive;

    rtc_bit_strobe u_strobe (
        .clk      (clk),
        .rst      (rst),
        .bus_mode (bus_mode),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ds_n     (ds_n),
        .rw       (rw),
        .act      (act),
        .fin      (fin)
    );

    rtc_bit_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .fin        (fin),
        .dio_i      (dio_i),
        .frame_rst  (frame_rst),
        .snap_data  (snap_data),
        .snap_addr  (snap_addr),
        .bit_cnt    (bit_cnt),
        .data_phase (data_phase),
        .out_bit    (out_bit),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    rtc_bit_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (snap_addr),
        .rd_data  (snap_data),
        .tone_sel (tone_sel)
    );

    rtc_bit_tone #(.TONE_DIV(TONE_DIV)) u_tone (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_32k),
        .tone (tone)
    );

    assign rd_drive = act.rd & data_phase;

    always_comb begin
        if (cs_n) begin
            dio_oe = tone_sel;
            dio_o  = tone_sel & tone;
        end else begin
            dio_oe = rd_drive;
            dio_o  = rd_drive & out_bit;
        end
    end

endmodule

// File: rtl/rtc_bit_port_chk.sv
module rtc_bit_port_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(ADDR_W + DATA_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_mode,
    input logic             cs_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             ds_n,
    input logic             frame_rst,
    input logic             dio_oe,
    input logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] ADDR_N = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(ADDR_W + DATA_W - 1);

    p_no_drive_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && bit_cnt < ADDR_N) |-> !dio_oe);

    p_drive_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && dio_oe) |-> (bus_mode ? !ds_n : (!rd_n && wr_n)));

    p_both_strobes_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !bus_mode && !rd_n && !wr_n) |-> !dio_oe);

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        frame_rst |=> (bit_cnt == '0));

    p_cnt_range_r10: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= LAST);

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt != $past(bit_cnt)) |->
            (bit_cnt == '0 || bit_cnt == $past(bit_cnt) + 1'b1));

endmodule

bind rtc_bit_port rtc_bit_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_mode  (bus_mode),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ds_n      (ds_n),
    .frame_rst (frame_rst),
    .dio_oe    (dio_oe),
    .bit_cnt   (bit_cnt)
);

// File: tb/rtc_bit_port_tb.sv
module rtc_bit_port_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_mode = 1'b0;
    logic cs_n = 1'b1;
    logic rd_n = 1'b1;
    logic wr_n = 1'b1;
    logic ds_n = 1'b1;
    logic rw = 1'b0;
    logic frame_rst = 1'b0;
    logic tick_32k = 1'b0;
    logic dio_i = 1'b0;
    logic dio_o;
    logic dio_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    rtc_bit_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_mode  (bus_mode),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ds_n      (ds_n),
        .rw        (rw),
        .frame_rst (frame_rst),
        .tick_32k  (tick_32k),
        .dio_i     (dio_i),
        .dio_o     (dio_o),
        .dio_oe    (dio_oe)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: collects read bits as each drive window closes.
    bit         rdg = 1'b0;
    bit         lastb = 1'b0;
    logic [7:0] acc = '0;
    int         nb = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n && dio_oe) begin
                rdg   = 1'b1;
                lastb = dio_o;
            end else if (rdg) begin
                rdg = 1'b0;
                acc = {lastb, acc[7:1]};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (exp_q.size() == 0) begin
                        check("R6 unexpected read byte", acc, 8'hxx);
                    end else begin
                        check(tag_q.pop_front(), acc, exp_q.pop_front());
                    end
                end
            end
        end
    end

    task automatic drv_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic access(bit is_rd, bit b, bit flip, bit cs_first);
        drv_edge();
        dio_i = b;
        cs_n  = 1'b0;
        if (bus_mode) begin
            rw   = is_rd;
            ds_n = 1'b0;
        end else if (is_rd) begin
            rd_n = 1'b0;
        end else begin
            wr_n = 1'b0;
        end
        drv_edge();
        if (flip) begin
            rw = ~rw;
            @(negedge clk);
            check("R7 direction held after rw change", {7'd0, dio_oe}, 8'd1);
        end
        drv_edge();
        if (cs_first) begin
            @(negedge clk);
            check("R4 drive while selected", {7'd0, dio_oe}, 8'd1);
            drv_edge();
            cs_n = 1'b1;
            @(negedge clk);
            check("R4 release on first deassert", {7'd0, dio_oe}, 8'd0);
            drv_edge();
        end
        cs_n = 1'b1;
        rd_n = 1'b1;
        wr_n = 1'b1;
        ds_n = 1'b1;
        drv_edge();
    endtask

    task automatic wr_frame(logic [3:0] a, logic [7:0] d);
        for (int i = 0; i < 4; i++) access(1'b0, a[i], 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) access(1'b0, d[i], 1'b0, 1'b0);
    endtask

    task automatic rd_frame(logic [3:0] a, logic [7:0] exp, string tag,
                            bit flip0, bit csf0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = 0; i < 4; i++) access(1'b0, a[i], 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) access(1'b1, 1'b0, flip0 && i == 0, csf0 && i == 0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            drv_edge();
            tick_32k = 1'b1;
            drv_edge();
            tick_32k = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check("R1 idle line released", {7'd0, dio_oe}, 8'd0);
        rd_frame(4'd5, 8'h00, "R1 register reset value", 1'b0, 1'b0);

        wr_frame(4'd3, 8'hA5);
        rd_frame(4'd3, 8'hA5, "R5 write then read", 1'b0, 1'b0);
        wr_frame(4'd12, 8'h3C);
        rd_frame(4'd12, 8'h3C, "R2 address LSB first", 1'b0, 1'b0);
        rd_frame(4'd3, 8'hA5, "R6 read leaves register intact", 1'b0, 1'b0);

        // R3: read strobe in the address phase is not counted
        drv_edge();
        cs_n = 1'b0;
        rd_n = 1'b0;
        @(negedge clk);
        check("R3 no drive in address phase", {7'd0, dio_oe}, 8'd0);
        drv_edge();
        cs_n = 1'b1;
        rd_n = 1'b1;
        drv_edge();
        wr_frame(4'd6, 8'h96);
        rd_frame(4'd6, 8'h96, "R3 frame not advanced", 1'b0, 1'b0);

        // R8: both strobes low together
        drv_edge();
        cs_n = 1'b0;
        rd_n = 1'b0;
        wr_n = 1'b0;
        @(negedge clk);
        check("R8 no drive with both strobes", {7'd0, dio_oe}, 8'd0);
        drv_edge();
        cs_n = 1'b1;
        rd_n = 1'b1;
        wr_n = 1'b1;
        drv_edge();
        rd_frame(4'd6, 8'h96, "R8 frame not advanced", 1'b0, 1'b0);

        rd_frame(4'd12, 8'h3C, "R4 early chip select release", 1'b0, 1'b1);

        // R9: abandon a partial frame
        access(1'b0, 1'b1, 1'b0, 1'b0);
        access(1'b0, 1'b0, 1'b0, 1'b0);
        drv_edge();
        frame_rst = 1'b1;
        drv_edge();
        frame_rst = 1'b0;
        wr_frame(4'd9, 8'h81);
        rd_frame(4'd9, 8'h81, "R9 restart after frame reset", 1'b0, 1'b0);

        wr_frame(4'd15, 8'h7E);
        rd_frame(4'd15, 8'h7E, "R10 back-to-back frames wrap", 1'b0, 1'b0);

        bus_mode = 1'b1;
        wr_frame(4'd7, 8'h5A);
        rd_frame(4'd7, 8'h5A, "R7 data-strobe mode write/read", 1'b1, 1'b0);
        rd_frame(4'd3, 8'hA5, "R7 data-strobe read", 1'b0, 1'b0);
        bus_mode = 1'b0;

        // R11: square-wave output while deselected
        wr_frame(4'd0, 8'h01);
        @(negedge clk);
        check("R11 drive with tone bit set", {7'd0, dio_oe}, 8'd1);
        check("R11 tone low first half", {7'd0, dio_o}, 8'd0);
        ticks(64);
        @(negedge clk);
        check("R11 tone high second half", {7'd0, dio_o}, 8'd1);
        ticks(64);
        @(negedge clk);
        check("R11 tone low after period", {7'd0, dio_o}, 8'd0);
        rd_frame(4'd0, 8'h01, "R11 tone register read", 1'b0, 1'b0);
        wr_frame(4'd0, 8'h00);
        @(negedge clk);
        check("R11 released with tone bit clear", {7'd0, dio_oe}, 8'd0);

        repeat (10) @(posedge clk);
        check("R6 scoreboard drained", 8'(exp_q.size()), 8'd0);
        done = 1'b1;
        finish_run();
    end

endmodule